// File: doc/BRIEF.md
# Swap-Priority Fair Arbiter

This block arbitrates among N requesters that share one network-on-chip output or link. Each requester owns a priority weight, and the weights always form a permutation of 0..N-1, so no two are ever equal. In every cycle the grant goes, combinationally, to the requesting source whose weight is highest. The grant is one-hot, and it is all zeros when nobody requests.

The fairness comes from exchanging stored weights, not from a rotating pointer. When two or more sources contend and the downstream side accepts the grant, the weights held by the contenders are exchanged on the next clock edge. The winner sinks to the lowest weight that any contender held. Each losing contender climbs to the next higher weight held by a contender. With two contenders this is a plain swap between winner and loser. With more, it is a chain of such exchanges. Sources that are not requesting keep their weights. The accept input freezes all state while the consumer is busy. The weight table is exported for observation.

Top module: `swarb_top`

## Requirements
- R1: After reset, requester i holds weight i. The weight of requester i sits in `weights_o[i*WT_W +: WT_W]`, with WT_W = 2 for the default N_REQ = 4.
- R2: At every clock edge after reset, the N weights are pairwise distinct.
- R3: `grant_o` has at most one bit set, the set bit is always a requesting source, and `grant_o` is zero when `req_i` is zero.
- R4: In the same cycle as the request, the grant goes to the requesting source with the highest weight.
- R5: When exactly one source requests, it is granted and no weight changes.
- R6: On an accepted grant with two or more requesters, on the next edge: the winner takes the lowest weight held by any requester; every losing requester takes the smallest requester weight above its own; non-requesters keep their weights.
- R7: While `accept_i` is low, no weight changes, whatever the request pattern.
- R8: While a source requests without pause, it loses at most M-1 accepted grants in a row, where M is the number of contenders (never more than N-1).
- R9: With no requests, no weight changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_REQ | Request vector, one bit per source |
| accept_i | input | 1 | High when the downstream side takes the current grant; qualifies the weight update |
| grant_o | output | N_REQ | One-hot grant, combinational from req_i and the weights |
| weights_o | output | N_REQ*WT_W | Current weight table, slot i at bits i*WT_W +: WT_W |

## Verification
The hardest state to reach from the ports is a source that has sunk to the lowest weight and must climb back under unbroken contention. Only a long run of accepted contests gets it there, and a stall or an idle cycle in between would hide the climb. The stimulus therefore holds fixed contender sets of four, three and two sources for many accepted cycles, with no gaps. The bench tracks each source's run of consecutive losses and checks it against the contender count. A reference weight table, updated by ranking the contenders, checks every grant and every weight after each edge. Stalled contests with all sources requesting show that the table stays frozen while the same winner is still presented.

// File: rtl/swarb_pkg.sv
package swarb_pkg;

    localparam int unsigned SWARB_DEF_REQ = 4;

    // Outcome of one arbitration cycle
    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_SOLO    = 2'd1,
        ARB_CONTEST = 2'd2
    } arb_kind_e;

    // Width of a weight able to hold 0..n-1
    function automatic int wt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Classify a cycle from the number of active requesters
    function automatic arb_kind_e arb_classify(input int unsigned cnt);
        if (cnt == 0)      return ARB_IDLE;
        else if (cnt == 1) return ARB_SOLO;
        else               return ARB_CONTEST;
    endfunction

endpackage

// File: rtl/swarb_pick.sv
module swarb_pick import swarb_pkg::*; #(
    parameter int N_REQ = 4,
    parameter int WT_W  = 2
) (
    input  logic [N_REQ-1:0]      req_i,
    input  logic [N_REQ*WT_W-1:0] wt_i,
    output logic [N_REQ-1:0]      grant_o,
    output arb_kind_e             kind_o
);

    logic            found;
    logic [WT_W-1:0] best_wt;
    int              best_idx;
    int unsigned     act_cnt;

    // Highest weight among the active requesters wins
    always_comb begin
        found    = 1'b0;
        best_wt  = '0;
        best_idx = 0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req_i[i] && (!found || (wt_i[i*WT_W +: WT_W] > best_wt))) begin
                found    = 1'b1;
                best_wt  = wt_i[i*WT_W +: WT_W];
                best_idx = i;
            end
        end
        grant_o = found ? (N_REQ'(1) << best_idx) : '0;
    end

    always_comb begin
        act_cnt = 0;
        for (int i = 0; i < N_REQ; i++) begin
            act_cnt = act_cnt + {31'd0, req_i[i]};
        end
        kind_o = arb_classify(act_cnt);
    end

endmodule

// File: rtl/swarb_wtable.sv
module swarb_wtable #(
    parameter int N_REQ = 4,
    parameter int WT_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_i,
    input  logic [N_REQ-1:0]      contend_i,
    input  logic [N_REQ-1:0]      win_i,
    output logic [N_REQ*WT_W-1:0] wt_o
);

    logic [WT_W-1:0] wt_q [N_REQ];

    for (genvar i = 0; i < N_REQ; i++) begin : g_slot
        logic [WT_W-1:0] cand;
        logic            hit;
        logic [WT_W-1:0] nxt;

        // Compare-exchange target: winner takes the lowest contender
        // weight, a loser the smallest contender weight above its own.
        always_comb begin
            hit  = 1'b0;
            cand = wt_q[i];
            for (int j = 0; j < N_REQ; j++) begin
                if (contend_i[j] && (win_i[i] || (wt_q[j] > wt_q[i]))
                    && (!hit || (wt_q[j] < cand))) begin
                    cand = wt_q[j];
                    hit  = 1'b1;
                end
            end
            nxt = (contend_i[i] && hit) ? cand : wt_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                wt_q[i] <= WT_W'(i);
            end else if (upd_i) begin
                wt_q[i] <= nxt;
            end
        end

        assign wt_o[i*WT_W +: WT_W] = wt_q[i];

        // After an accepted contest the old winner sits below every other contender
        for (genvar j = 0; j < N_REQ; j++) begin : g_sink
            if (i != j) begin : g_pair
                AST_WINNER_SINKS: assert property (@(posedge clk) disable iff (rst)
                    (upd_i && win_i[i] && contend_i[j]) |=> (wt_q[i] < wt_q[j])); // R6
            end
        end
    end

    // The table stays a permutation
    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N_REQ; i++) begin
                for (int j = i + 1; j < N_REQ; j++) begin
                    AST_WEIGHTS_DISTINCT: assert (wt_q[i] != wt_q[j]) // R2
                        else $error("weights of %0d and %0d coincide", i, j);
                end
            end
        end
    end

endmodule

// File: rtl/swarb_top.sv
module swarb_top import swarb_pkg::*; #(
    parameter  int N_REQ = SWARB_DEF_REQ,
    localparam int WT_W  = wt_bits(N_REQ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_REQ-1:0]      req_i,
    input  logic                  accept_i,
    output logic [N_REQ-1:0]      grant_o,
    output logic [N_REQ*WT_W-1:0] weights_o
);

    localparam int LOSS_W = $clog2(N_REQ) + 1;

    arb_kind_e kind;
    logic      upd;

    swarb_pick #(.N_REQ(N_REQ), .WT_W(WT_W)) u_pick (
        .req_i   (req_i),
        .wt_i    (weights_o),
        .grant_o (grant_o),
        .kind_o  (kind)
    );

    assign upd = (kind == ARB_CONTEST) && accept_i;

    swarb_wtable #(.N_REQ(N_REQ), .WT_W(WT_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (upd),
        .contend_i (req_i),
        .win_i     (grant_o),
        .wt_o      (weights_o)
    );

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R3
    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
        ((grant_o & ~req_i) == '0)); // R3
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |-> (grant_o == '0)); // R3
    AST_LIVE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |-> (grant_o != '0)); // R4
    AST_SOLO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($countones(req_i) == 1) |=> $stable(weights_o)); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(weights_o)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> $stable(weights_o)); // R9

    for (genvar i = 0; i < N_REQ; i++) begin : g_chk
        logic [LOSS_W-1:0] losses;

        for (genvar j = 0; j < N_REQ; j++) begin : g_cmp
            if (i != j) begin : g_pair
                AST_TOP_WINS: assert property (@(posedge clk) disable iff (rst)
                    (grant_o[i] && req_i[j])
                    |-> (weights_o[i*WT_W +: WT_W] > weights_o[j*WT_W +: WT_W])); // R4
            end
        end

        // Consecutive accepted losses of a source that keeps requesting
        always_ff @(posedge clk) begin
            if (rst || !req_i[i] || grant_o[i]) begin
                losses <= '0;
            end else if (accept_i) begin
                losses <= losses + 1'b1;
            end
        end

        AST_NO_STARVE: assert property (@(posedge clk) disable iff (rst)
            (losses <= LOSS_W'(N_REQ - 1))); // R8
    end

endmodule

// File: tb/tb_swarb_top.sv
`timescale 1ns/1ps
module tb_swarb_top;

    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         accept = 1'b0;
    logic [N-1:0] grant;
    logic [N*W-1:0] weights;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    int mw [N];
    logic [N-1:0] last_grant;
    string prev_tag = "R1 reset";

    always #2.5 clk = ~clk;

    swarb_top #(.N_REQ(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .accept_i (accept),
        .grant_o  (grant),
        .weights_o(weights)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [N-1:0] r);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(r[i]);
        return c;
    endfunction

    function automatic logic [N-1:0] model_pick(input logic [N-1:0] r);
        int bi = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (bi < 0 || mw[i] > mw[bi])) bi = i;
        return (bi < 0) ? '0 : (N'(1) << bi);
    endfunction

    // Rank contenders by weight, highest first; rank 0 drops to the
    // last rank's weight, every other rank inherits the one above it.
    task automatic model_update(input logic [N-1:0] r);
        int order [N];
        int m = 0;
        int nw [N];
        bit used [N];
        for (int i = 0; i < N; i++) begin nw[i] = mw[i]; used[i] = 1'b0; end
        for (int k = 0; k < N; k++) begin
            int bi = -1;
            for (int i = 0; i < N; i++)
                if (r[i] && !used[i] && (bi < 0 || mw[i] > mw[bi])) bi = i;
            if (bi >= 0) begin used[bi] = 1'b1; order[m] = bi; m++; end
        end
        nw[order[0]] = mw[order[m-1]];
        for (int k = 1; k < m; k++) nw[order[k]] = mw[order[k-1]];
        for (int i = 0; i < N; i++) mw[i] = nw[i];
    endtask

    task automatic check_table(input string tag);
        bit distinct = 1'b1;
        for (int i = 0; i < N; i++) begin
            chk({tag, " weight"}, int'(weights[i*W +: W]), mw[i]);
            for (int j = i + 1; j < N; j++)
                if (weights[i*W +: W] == weights[j*W +: W]) distinct = 1'b0;
        end
        chk({tag, " R2 distinct"}, int'(distinct), 1);
    endtask

    task automatic step(input logic [N-1:0] r, input logic a, input string tag);
        @(negedge clk);
        req = r;
        accept = a;
        #1;
        check_table(prev_tag);
        last_grant = grant;
        chk({tag, " R4 R3 grant"}, int'(grant), int'(model_pick(r)));
        @(posedge clk);
        if (a && popc(r) >= 2) model_update(r);
        prev_tag = tag;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) mw[i] = i;
        #1;
        for (int i = 0; i < N; i++)
            chk("R1 reset weight", int'(weights[i*W +: W]), i);
        chk("R3 reset grant", int'(grant), 0);
    endtask

    task automatic t_idle;
        for (int k = 0; k < 3; k++) step('0, 1'b1, "R9 idle");
    endtask

    task automatic t_solo;
        for (int i = 0; i < N; i++) step(N'(1) << i, 1'b1, "R5 solo");
        step(4'b0100, 1'b1, "R5 solo repeat");
    endtask

    task automatic t_pair;
        step(4'b0011, 1'b1, "R6 pair");
        step(4'b0011, 1'b1, "R6 pair again");
        step(4'b0011, 1'b1, "R6 pair third");
    endtask

    task automatic t_stall;
        logic [N-1:0] g0;
        step(4'b1111, 1'b0, "R7 stall");
        g0 = last_grant;
        step(4'b1111, 1'b0, "R7 stall");
        chk("R7 stall same winner", int'(last_grant), int'(g0));
        step(4'b0110, 1'b0, "R7 stall subset");
    endtask

    task automatic t_subset;
        step(4'b1101, 1'b1, "R6 subset a");
        step(4'b0110, 1'b1, "R6 subset b");
        step(4'b1011, 1'b1, "R6 subset c");
        step(4'b1110, 1'b1, "R6 subset d");
    endtask

    task automatic t_sustain(input logic [N-1:0] r, input int cycles, input string tag);
        int losses [N];
        int worst = 0;
        int wins [N];
        int m = popc(r);
        bit all_won = 1'b1;
        for (int i = 0; i < N; i++) begin losses[i] = 0; wins[i] = 0; end
        for (int c = 0; c < cycles; c++) begin
            step(r, 1'b1, tag);
            for (int i = 0; i < N; i++) begin
                if (r[i]) begin
                    if (last_grant[i]) begin
                        losses[i] = 0;
                        wins[i]++;
                    end else begin
                        losses[i]++;
                        if (losses[i] > worst) worst = losses[i];
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) if (r[i] && wins[i] == 0) all_won = 1'b0;
        chk({tag, " R8 every contender served"}, int'(all_won), 1);
        chk({tag, " R8 worst wait within bound"}, int'(worst <= m - 1), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_solo();
        t_pair();
        t_stall();
        t_subset();
        t_sustain(4'b1111, 12, "R8 four");
        t_sustain(4'b0111, 9, "R8 three");
        t_sustain(4'b1010, 6, "R8 two");
        step('0, 1'b0, "R9 final");
        step('0, 1'b1, "R9 final");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule